// File: doc/BRIEF.md
# Reflection Peak and Threshold Capture Unit

This block is the capture half of a cable diagnostic. Once a test pulse has been sent down a twisted pair, the block receives the digitised line response as a stream of signed samples. Each sample comes with a one-cycle valid strobe. Each strobe is one 8 ns step of a time base that starts at zero on the start trigger.

Within a programmable window of time steps, the block looks for two things. The first is the extreme sample, either the largest or the smallest by signed order depending on the polarity setting, together with the step at which it first appeared. The second is the first step at which a sample reached a programmable threshold. The window lets software skip the launched pulse and look only at later reflections.

The configuration is taken on the start trigger. The results stay readable after the done flag rises, until the next start.

Top module: `tdr_capture`

## Requirements
- R1: After reset, busy, done and thr_found are 0, and peak_val, peak_time and thr_time are 0.
- R2: A start pulse clears all results, sets busy and clears done from the next cycle. The first strobe accepted after it is time step 0.
- R3: Each accepted strobe (smp_valid high while busy) advances the time step by exactly one. Cycles without a strobe do not advance it.
- R4: Samples whose time step lies outside the inclusive range win_lo..win_hi change neither the peak nor the threshold results.
- R5: With cfg_find_min = 0, peak_val is the largest in-window sample by signed order. peak_time is the earliest step holding that value, so a later equal sample does not move it.
- R6: With cfg_find_min = 1, peak_val is the smallest in-window sample by signed order, and a tie keeps the earlier step.
- R7: thr_found rises on the first in-window sample that is at or above cfg_thresh (max mode) or at or below it (min mode), and thr_time records that step. Later crossings change neither.
- R8: The strobe at step win_hi ends the capture: done rises and busy falls in the same cycle. Strobes after that, and strobes while idle, leave every result unchanged until the next start.
- R9: Window, polarity and threshold are sampled on the start pulse. Changing the configuration inputs during a capture has no effect on it.
- R10: A strobe arriving in the same cycle as start is discarded and does not count as a time step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle trigger that begins a capture |
| smp_valid | input | 1 | Sample strobe, one per 8 ns time step |
| smp_data | input | SMP_W | Signed ADC sample |
| cfg_win_lo | input | TIME_W | First time step of the window |
| cfg_win_hi | input | TIME_W | Last time step of the window, which also ends the capture |
| cfg_find_min | input | 1 | 0 searches for the maximum, 1 for the minimum |
| cfg_thresh | input | SMP_W | Signed threshold level |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Capture complete and results valid |
| peak_val | output | SMP_W | Extreme sample found |
| peak_time | output | TIME_W | Time step of the first occurrence of the extreme |
| thr_found | output | 1 | The threshold was reached inside the window |
| thr_time | output | TIME_W | Time step of the first threshold crossing |

## Verification
The captures use four waveform shapes:
- A rising ramp. It shows whether the window end truncates the search and whether a threshold beyond the window stays unfound.
- A large launch pulse followed by two equal reflections. It tells window exclusion from inclusion and first-occurrence from last-occurrence tie handling.
- Negative dips. These exercise minimum mode and signed ordering.
- A triangle. Its threshold crossing comes before the peak, which separates the two recorded times.

Directed runs cover the following:
- Strobes with idle gaps.
- Configuration changes in the middle of a capture.
- A strobe coincident with start.
- Extreme samples after done and while idle, which must not disturb the held results.

// File: rtl/tdr_pkg.sv
`timescale 1ns/1ps
package tdr_pkg;

  typedef enum logic {POL_MAX = 1'b0, POL_MIN = 1'b1} pol_e;

  // Signed comparison: is sample s a strictly better extreme than cur?
  function automatic logic is_better(input int s, input int cur, input pol_e pol);
    return (pol == POL_MIN) ? (s < cur) : (s > cur);
  endfunction

  // Threshold reached in the active polarity (inclusive).
  function automatic logic crosses(input int s, input int th, input pol_e pol);
    return (pol == POL_MIN) ? (s <= th) : (s >= th);
  endfunction

  // Inclusive time window test.
  function automatic logic in_window(input int unsigned t, input int unsigned lo,
                                     input int unsigned hi);
    return (t >= lo) && (t <= hi);
  endfunction

endpackage

// File: rtl/tdr_timebase.sv
`timescale 1ns/1ps
module tdr_timebase #(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              smp_valid,
  input  logic [TIME_W-1:0] win_lo,
  input  logic [TIME_W-1:0] win_hi,
  output logic [TIME_W-1:0] t_cnt,
  output logic              busy,
  output logic              done,
  output logic              tick_acc,
  output logic              samp_in_win
);
  import tdr_pkg::*;

  logic last_step;

  assign tick_acc    = busy & smp_valid & ~start;
  assign samp_in_win = tick_acc & in_window(32'(t_cnt), 32'(win_lo), 32'(win_hi));
  assign last_step   = (t_cnt >= win_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_cnt <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else if (start) begin
      t_cnt <= '0;
      busy  <= 1'b1;
      done  <= 1'b0;
    end else if (tick_acc) begin
      t_cnt <= t_cnt + 1'b1;
      if (last_step) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdr_extreme_track.sv
`timescale 1ns/1ps
module tdr_extreme_track #(
  parameter int SMP_W  = 10,
  parameter int TIME_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    hit,
  input  tdr_pkg::pol_e           pol,
  input  logic signed [SMP_W-1:0] smp,
  input  logic [TIME_W-1:0]       t_now,
  output logic signed [SMP_W-1:0] peak_val,
  output logic [TIME_W-1:0]       peak_time,
  output logic                    peak_seen
);
  import tdr_pkg::*;

  logic take;

  assign take = hit & (~peak_seen | is_better(int'(smp), int'(peak_val), pol));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_val  <= '0;
      peak_time <= '0;
      peak_seen <= 1'b0;
    end else if (clear) begin
      peak_val  <= '0;
      peak_time <= '0;
      peak_seen <= 1'b0;
    end else if (take) begin
      peak_val  <= smp;
      peak_time <= t_now;
      peak_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/tdr_cross_detect.sv
`timescale 1ns/1ps
module tdr_cross_detect #(
  parameter int SMP_W  = 10,
  parameter int TIME_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    hit,
  input  tdr_pkg::pol_e           pol,
  input  logic signed [SMP_W-1:0] thresh,
  input  logic signed [SMP_W-1:0] smp,
  input  logic [TIME_W-1:0]       t_now,
  output logic                    found,
  output logic [TIME_W-1:0]       found_time
);
  import tdr_pkg::*;

  logic first_cross;

  assign first_cross = hit & ~found & crosses(int'(smp), int'(thresh), pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found      <= 1'b0;
      found_time <= '0;
    end else if (clear) begin
      found      <= 1'b0;
      found_time <= '0;
    end else if (first_cross) begin
      found      <= 1'b1;
      found_time <= t_now;
    end
  end
endmodule

// File: rtl/tdr_capture.sv
`timescale 1ns/1ps
module tdr_capture #(
  parameter int SMP_W  = 10,
  parameter int TIME_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic [TIME_W-1:0]       cfg_win_lo,
  input  logic [TIME_W-1:0]       cfg_win_hi,
  input  logic                    cfg_find_min,
  input  logic signed [SMP_W-1:0] cfg_thresh,
  output logic                    busy,
  output logic                    done,
  output logic signed [SMP_W-1:0] peak_val,
  output logic [TIME_W-1:0]       peak_time,
  output logic                    thr_found,
  output logic [TIME_W-1:0]       thr_time
);
  import tdr_pkg::*;

  // Configuration held for the whole capture
  logic [TIME_W-1:0]       win_lo_q;
  logic [TIME_W-1:0]       win_hi_q;
  logic signed [SMP_W-1:0] thresh_q;
  pol_e                    cfg_min_q;

  // Internal events, named for the checker
  logic [TIME_W-1:0] t_cnt;
  logic              tick_acc;
  logic              samp_in_win;
  logic              peak_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_lo_q  <= '0;
      win_hi_q  <= '0;
      thresh_q  <= '0;
      cfg_min_q <= POL_MAX;
    end else if (start) begin
      win_lo_q  <= cfg_win_lo;
      win_hi_q  <= cfg_win_hi;
      thresh_q  <= cfg_thresh;
      cfg_min_q <= cfg_find_min ? POL_MIN : POL_MAX;
    end
  end

  tdr_timebase #(.TIME_W(TIME_W)) u_tb (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .smp_valid   (smp_valid),
    .win_lo      (win_lo_q),
    .win_hi      (win_hi_q),
    .t_cnt       (t_cnt),
    .busy        (busy),
    .done        (done),
    .tick_acc    (tick_acc),
    .samp_in_win (samp_in_win)
  );

  tdr_extreme_track #(.SMP_W(SMP_W), .TIME_W(TIME_W)) u_peak (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .hit       (samp_in_win),
    .pol       (cfg_min_q),
    .smp       (smp_data),
    .t_now     (t_cnt),
    .peak_val  (peak_val),
    .peak_time (peak_time),
    .peak_seen (peak_seen)
  );

  tdr_cross_detect #(.SMP_W(SMP_W), .TIME_W(TIME_W)) u_thr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start),
    .hit        (samp_in_win),
    .pol        (cfg_min_q),
    .thresh     (thresh_q),
    .smp        (smp_data),
    .t_now      (t_cnt),
    .found      (thr_found),
    .found_time (thr_time)
  );
endmodule

// File: rtl/tdr_capture_chk.sv
`timescale 1ns/1ps
module tdr_capture_chk #(
  parameter int SMP_W  = 10,
  parameter int TIME_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic signed [SMP_W-1:0] peak_val,
  input logic [TIME_W-1:0]       peak_time,
  input logic                    thr_found,
  input logic [TIME_W-1:0]       thr_time,
  input logic [TIME_W-1:0]       t_cnt,
  input logic                    tick_acc,
  input logic                    peak_seen,
  input logic                    cfg_min_q,
  input logic [TIME_W-1:0]       win_lo_q,
  input logic [TIME_W-1:0]       win_hi_q
);

  p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && !done && !thr_found && !peak_seen && (t_cnt == '0));

  p_time_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_acc |=> t_cnt == TIME_W'($past(t_cnt) + 1'b1));

  p_peak_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    peak_seen |-> (peak_time >= win_lo_q) && (peak_time <= win_hi_q));

  p_max_never_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start && peak_seen && !cfg_min_q |=> peak_val >= $past(peak_val));

  p_min_never_rises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start && peak_seen && cfg_min_q |=> peak_val <= $past(peak_val));

  p_cross_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    thr_found && !start |=> thr_found && $stable(thr_time));

  p_cross_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thr_found) |-> (thr_time >= win_lo_q) && (thr_time <= win_hi_q));

  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_results_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(peak_val) && $stable(peak_time)
                       && $stable(thr_found) && $stable(thr_time));

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start |=> $stable(cfg_min_q) && $stable(win_lo_q) && $stable(win_hi_q));

endmodule

bind tdr_capture tdr_capture_chk #(.SMP_W(SMP_W), .TIME_W(TIME_W)) u_chk (.*);

// File: tb/tdr_capture_tb_top.sv
`timescale 1ns/1ps
module tdr_capture_tb_top;
  localparam int SMP_W  = 10;
  localparam int TIME_W = 8;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    start = 1'b0;
  logic                    smp_valid = 1'b0;
  logic signed [SMP_W-1:0] smp_data = '0;
  logic [TIME_W-1:0]       cfg_win_lo = '0;
  logic [TIME_W-1:0]       cfg_win_hi = '0;
  logic                    cfg_find_min = 1'b0;
  logic signed [SMP_W-1:0] cfg_thresh = '0;
  logic                    busy, done, thr_found;
  logic signed [SMP_W-1:0] peak_val;
  logic [TIME_W-1:0]       peak_time, thr_time;

  int n_checks = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tdr_capture #(.SMP_W(SMP_W), .TIME_W(TIME_W)) dut_i (.*);

  typedef struct packed {
    logic [7:0] lo;
    logic [7:0] hi;
    logic       mn;
    logic [9:0] thr;
    logic [1:0] pat;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd5,  8'd40, 1'b0, 10'd100,  2'd1},  // reflection after excluded pulse, tie
    '{8'd0,  8'd40, 1'b0, 10'd100,  2'd1},  // pulse inside window
    '{8'd5,  8'd40, 1'b1, -10'sd100, 2'd2}, // negative dips, min mode
    '{8'd5,  8'd30, 1'b0, 10'd0,    2'd0},  // ramp cut off by window end
    '{8'd10, 8'd50, 1'b0, 10'd30,   2'd3},  // triangle, crossing before peak
    '{8'd0,  8'd20, 1'b1, -10'sd50, 2'd0}   // ramp, min at step 0
  };

  function automatic int pat_smp(input int p, input int t);
    case (p)
      0: return t * 3 - 100;
      1: return (t == 2) ? 400 : ((t == 20 || t == 25) ? 150 : 5);
      2: return (t == 2) ? -300 : ((t == 18 || t == 22) ? -120 : 0);
      default: return 50 - ((t > 30) ? (t - 30) : (30 - t)) * 4;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int v);
    smp_valid = 1'b1;
    smp_data  = SMP_W'(v);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic run_capture(input int lo, input int hi, input bit mn, input int thr,
                             input int p, input bit gaps, input bit scramble,
                             input string req);
    int ext, ext_t, ft;
    bit f;
    // expected: extreme value first, then earliest step holding it
    ext = pat_smp(p, lo);
    for (int t = lo; t <= hi; t++)
      if (mn ? (pat_smp(p, t) < ext) : (pat_smp(p, t) > ext)) ext = pat_smp(p, t);
    ext_t = -1;
    for (int t = hi; t >= lo; t--) if (pat_smp(p, t) == ext) ext_t = t;
    f = 0; ft = 0;
    for (int t = hi; t >= lo; t--)
      if (mn ? (pat_smp(p, t) <= thr) : (pat_smp(p, t) >= thr)) begin f = 1; ft = t; end

    cfg_win_lo = TIME_W'(lo); cfg_win_hi = TIME_W'(hi);
    cfg_find_min = mn; cfg_thresh = SMP_W'(thr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done && !thr_found && peak_val == 0, "R2", "start clears", {busy, done, thr_found}, 3'b100);
    if (scramble) begin  // R9: configuration changes after start must be ignored
      cfg_win_lo = '0; cfg_win_hi = 8'd3; cfg_find_min = ~mn; cfg_thresh = SMP_W'(mn ? 500 : -500);
    end
    for (int t = 0; t <= hi; t++) begin
      if (t == hi) check(busy && !done, "R8", "still busy before last step", busy, 1);
      tick(pat_smp(p, t));
      if (gaps) begin @(negedge clk); @(negedge clk); end
    end
    check(done && !busy, {req, " R8"}, "done after win_hi step", {done, busy}, 2'b10);
    check(peak_val == SMP_W'(ext), {req, mn ? " R6" : " R5"}, "peak value", int'(peak_val), ext);
    check(int'(peak_time) == ext_t, {req, mn ? " R6" : " R5"}, "peak time", int'(peak_time), ext_t);
    check(thr_found == f, {req, " R7"}, "threshold found", thr_found, f);
    if (f) check(int'(thr_time) == ft, {req, " R7"}, "threshold time", int'(thr_time), ft);
    // strobes after done carry extreme values that would win if accepted
    for (int k = 0; k < 3; k++) tick(mn ? -512 : 511);
    check(peak_val == SMP_W'(ext) && int'(peak_time) == ext_t && thr_found == f,
          "R8", "results hold after done", int'(peak_val), ext);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !thr_found && peak_val == 0 && peak_time == 0 && thr_time == 0,
          "R1", "reset state", {busy, done, thr_found}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: strobes while idle are ignored
    tick(400);
    tick(300);
    check(!busy && !done && peak_val == 0 && !thr_found, "R8", "idle strobes ignored", int'(peak_val), 0);

    // table-driven captures (R4 via window exclusions in entries 0, 2, 3, 4)
    for (int i = 0; i < 6; i++)
      run_capture(int'(VECS[i].lo), int'(VECS[i].hi), VECS[i].mn, int'($signed(VECS[i].thr)),
                  int'(VECS[i].pat), 1'b0, 1'b0, "R4");

    // R3: idle cycles between strobes do not advance the time step
    run_capture(10, 50, 1'b0, 30, 3, 1'b1, 1'b0, "R3");
    // R9: configuration changed mid-capture
    run_capture(5, 40, 1'b0, 100, 1, 1'b0, 1'b1, "R9");

    // R10: strobe coincident with start is discarded
    cfg_win_lo = '0; cfg_win_hi = 8'd4; cfg_find_min = 1'b0; cfg_thresh = 10'sd200;
    start = 1'b1; smp_valid = 1'b1; smp_data = 10'sd300;
    @(negedge clk);
    start = 1'b0; smp_valid = 1'b0;
    tick(7); tick(9); tick(9); tick(3);
    check(busy, "R10", "still busy after four strobes", busy, 1);
    tick(1);
    check(done, "R10", "done after fifth strobe", done, 1);
    check(peak_val == 10'sd9 && peak_time == 8'd1, "R10", "peak ignores start strobe",
          int'(peak_val), 9);
    check(!thr_found, "R10", "no crossing from discarded strobe", thr_found, 0);

    // R2: a new start clears held results
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(peak_val == 0 && peak_time == 0 && !done && busy, "R2", "restart clears results",
          int'(peak_val), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule